// File: doc/BRIEF.md
# Dual-Edge Nibble Counter with Software Strobe

This block is a small 4-bit event counter. It can work as a short timer, as an edge-triggered interrupt source, or as the low stage of a wider count. It advances from one of two sources.

- **External pin.** The pin is brought into the system clock domain through a synchronizer. When the pin source is selected, the counter steps once on every rising edge and once on every falling edge of the pin.
- **Software strobe.** A one-cycle strobe adds one to the count in every source mode. Firmware can use it to force an overflow, which acts as a software interrupt.

When the count wraps past its top value, three things happen:

- a sticky overflow flag is set;
- an interrupt output follows that flag when the enable input is high;
- a one-cycle carry pulse is issued, which can clock an 8-bit counter above this one to form a 12-bit count.

Firmware can also write the count directly. Loading the top value (0xF) arms the block so that the next pin edge overflows it. The overflow flag then behaves as an extra edge-triggered external interrupt.

Top module: `nibble_edge_counter`

## Requirements
- R1: While and after reset, `count` is 0 and `ovfFlag`, `irq` and `carryOut` are 0.
- R2: A cycle with `strobe` high and no count write adds one to `count` at the next clock edge, whatever `srcSel` holds.
- R3: With `srcSel` = 2'b01, each rising and each falling edge of `extPin` adds one to `count`. The new value shows after the third rising clock edge that follows the pin change, provided the pin is held for at least three cycles.
- R4: With `srcSel` = 2'b00, 2'b10 or 2'b11, pin edges leave `count` unchanged.
- R5: An increment that takes `count` from 0xF past zero sets `ovfFlag` at the same edge. The flag then stays set until it is cleared.
- R6: `flagClr` high for a cycle clears `ovfFlag` at the next edge. If an overflow happens in that same cycle, the flag stays set.
- R7: `irq` equals `ovfFlag` AND `ovfIntEn`, with no added cycle of delay.
- R8: `carryOut` is high for exactly the one cycle that starts at the edge where the count wraps.
- R9: `wrCount` loads `wrData` at the next edge and takes priority over any increment in that cycle. A load never sets `ovfFlag` and never raises `carryOut`.
- R10: A strobe and a pin edge that arrive in the same cycle add two. From 0xF this gives 0x1 and counts as an overflow.
- R11: After 0xF is loaded with `srcSel` = 2'b01, the next single pin edge sets `ovfFlag` and `carryOut`, and raises `irq` when it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSel | input | 2 | Count source: 00 strobe only, 01 pin on both edges, 10/11 no pin counting |
| extPin | input | 1 | Asynchronous external count pin |
| strobe | input | 1 | Software count strobe, one cycle |
| wrCount | input | 1 | Count register write enable |
| wrData | input | 4 | Value to load into the count |
| flagClr | input | 1 | Write-one-to-clear of the overflow flag |
| ovfIntEn | input | 1 | Overflow interrupt enable |
| count | output | 4 | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| carryOut | output | 1 | One-cycle wrap pulse for a higher counter stage |

## Verification
The block's results arrive with different delays:

- A strobe, a count write or a flag clear shows on the outputs after one clock edge.
- A pin change needs three edges: two synchronizer stages, then the counter update.
- `irq` follows the flag and the enable input directly.

The scoreboard queues one expected item per driven cycle and compares it half a cycle after the edge that should produce it. Pin tests are written as a change followed by two cycles in which the count has not moved, then the cycle in which it has. This pins down the exact cycle of arrival, not just the final value.

// File: rtl/nibcnt_pkg.sv
package nibcnt_pkg;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_PIN   = 2'b01,
    SRC_SHIFT = 2'b10,
    SRC_SPARE = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic incStrobe;
    logic incPin;
    logic load;
    logic clrFlag;
  } ctrlStrobes_t;

endpackage

// File: rtl/nibcnt_ctrl.sv
module nibcnt_ctrl
  import nibcnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   srcSel,
  input  logic         extPin,
  input  logic         strobe,
  input  logic         wrCount,
  input  logic         flagClr,
  output ctrlStrobes_t ctl
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   pinPrev;
  logic                   pinEdge;
  logic                   pinSelected;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= extPin;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else       syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= syncChain[LAST];
  end

  assign pinEdge     = syncChain[LAST] ^ pinPrev;
  assign pinSelected = (srcSel_e'(srcSel) == SRC_PIN);

  always_comb begin
    ctl.incStrobe = strobe;
    ctl.incPin    = pinEdge & pinSelected;
    ctl.load      = wrCount;
    ctl.clrFlag   = flagClr;
  end

endmodule

// File: rtl/nibcnt_dp.sv
module nibcnt_dp
  import nibcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     ctl,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count,
  output logic             ovfFlag,
  output logic             carryOut
);

  localparam int SW = WIDTH + 1;

  logic [SW-1:0] sum;
  logic          wrap;

  assign sum  = {1'b0, count} + SW'(ctl.incStrobe) + SW'(ctl.incPin);
  assign wrap = sum[WIDTH] & ~ctl.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      carryOut <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      count    <= ctl.load ? wrData : sum[WIDTH-1:0];
      carryOut <= wrap;
      ovfFlag  <= (ovfFlag & ~ctl.clrFlag) | wrap;
    end
  end

endmodule

// File: rtl/nibble_edge_counter.sv
module nibble_edge_counter
  import nibcnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       srcSel,
  input  logic             extPin,
  input  logic             strobe,
  input  logic             wrCount,
  input  logic [WIDTH-1:0] wrData,
  input  logic             flagClr,
  input  logic             ovfIntEn,
  output logic [WIDTH-1:0] count,
  output logic             ovfFlag,
  output logic             irq,
  output logic             carryOut
);

  ctrlStrobes_t ctl;

  nibcnt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .extPin(extPin),
    .strobe(strobe), .wrCount(wrCount), .flagClr(flagClr), .ctl(ctl)
  );

  nibcnt_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .count(count), .ovfFlag(ovfFlag), .carryOut(carryOut)
  );

  assign irq = ovfFlag & ovfIntEn;

endmodule

// File: rtl/nibble_edge_counter_chk.sv
module nibble_edge_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       srcSel,
  input logic             strobe,
  input logic             wrCount,
  input logic [WIDTH-1:0] wrData,
  input logic             flagClr,
  input logic             ovfIntEn,
  input logic [WIDTH-1:0] count,
  input logic             ovfFlag,
  input logic             irq,
  input logic             carryOut
);

  logic [WIDTH-1:0] cntPlusOne;
  assign cntPlusOne = count + 1'b1;

  AST_STROBE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && !wrCount && srcSel != 2'b01) |=> count == $past(cntPlusOne)); // R2
  AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel != 2'b01 && !strobe && !wrCount) |=> count == $past(count)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag); // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    irq == (ovfFlag && ovfIntEn)); // R7
  AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |=> !carryOut); // R8
  AST_CARRY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |-> ovfFlag); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> (count == $past(wrData)) && !carryOut); // R9

endmodule

bind nibble_edge_counter nibble_edge_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .srcSel(srcSel), .strobe(strobe),
  .wrCount(wrCount), .wrData(wrData), .flagClr(flagClr),
  .ovfIntEn(ovfIntEn), .count(count), .ovfFlag(ovfFlag),
  .irq(irq), .carryOut(carryOut)
);

// File: tb/nibble_edge_counter_tb.sv
module nibble_edge_counter_tb;

  typedef struct {
    string      req;
    logic [3:0] eCnt;
    logic       eFlag;
    logic       eCarry;
    logic       eIrq;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] srcSel = 2'b00;
  logic       extPin = 1'b0;
  logic       strobe = 1'b0;
  logic       wrCount = 1'b0;
  logic [3:0] wrData = 4'h0;
  logic       flagClr = 1'b0;
  logic       ovfIntEn = 1'b0;
  logic [3:0] count;
  logic       ovfFlag, irq, carryOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  nibble_edge_counter u_dut (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .extPin(extPin),
    .strobe(strobe), .wrCount(wrCount), .wrData(wrData),
    .flagClr(flagClr), .ovfIntEn(ovfIntEn), .count(count),
    .ovfFlag(ovfFlag), .irq(irq), .carryOut(carryOut)
  );

  // Monitor: compares one queued item half a cycle after its edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (count !== it.eCnt || ovfFlag !== it.eFlag ||
            carryOut !== it.eCarry || irq !== it.eIrq) begin
          fails++;
          $display("FAIL %s: cnt/flag/carry/irq got %h/%b/%b/%b expected %h/%b/%b/%b",
                   it.req, count, ovfFlag, carryOut, irq,
                   it.eCnt, it.eFlag, it.eCarry, it.eIrq);
        end
      end
    end
  end

  // Driver step: inputs already set; push expectation after the edge
  task automatic step(input string req, input logic [3:0] c,
                      input logic f, input logic cy, input logic i);
    expItem_t it;
    @(posedge clk);
    #1;
    strobe = 1'b0; wrCount = 1'b0; flagClr = 1'b0;
    it.req = req; it.eCnt = c; it.eFlag = f; it.eCarry = cy; it.eIrq = i;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(5 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (count !== 4'h0 || ovfFlag !== 1'b0 || irq !== 1'b0 || carryOut !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset outputs got %h/%b/%b/%b expected 0/0/0/0",
               count, ovfFlag, irq, carryOut);
    end
    rstN = 1'b1;
    #1;

    // R2: strobe in strobe-only mode
    strobe = 1'b1; step("R2", 4'h1, 0, 0, 0);
    step("R2", 4'h1, 0, 0, 0);

    // R4: pin edges ignored in modes 00 and 10
    extPin = 1'b1;
    repeat (4) step("R4", 4'h1, 0, 0, 0);
    extPin = 1'b0;
    repeat (4) step("R4", 4'h1, 0, 0, 0);
    srcSel = 2'b10; extPin = 1'b1;
    repeat (4) step("R4", 4'h1, 0, 0, 0);
    extPin = 1'b0;
    repeat (4) step("R4", 4'h1, 0, 0, 0);

    // R3: both pin edges count, third edge after the change
    srcSel = 2'b01; extPin = 1'b1;
    step("R3", 4'h1, 0, 0, 0);
    step("R3", 4'h1, 0, 0, 0);
    step("R3", 4'h2, 0, 0, 0);
    step("R3", 4'h2, 0, 0, 0);
    extPin = 1'b0;
    step("R3", 4'h2, 0, 0, 0);
    step("R3", 4'h2, 0, 0, 0);
    step("R3", 4'h3, 0, 0, 0);
    step("R3", 4'h3, 0, 0, 0);

    // R9 load, R5 wrap, R8 carry pulse
    wrCount = 1'b1; wrData = 4'hE; step("R9", 4'hE, 0, 0, 0);
    strobe = 1'b1; step("R2", 4'hF, 0, 0, 0);
    strobe = 1'b1; step("R5", 4'h0, 1, 1, 0);
    step("R8", 4'h0, 1, 0, 0);

    // R7 enable, R6 clear
    ovfIntEn = 1'b1; step("R7", 4'h0, 1, 0, 1);
    flagClr = 1'b1; step("R6", 4'h0, 0, 0, 0);

    // R6 clear and new overflow in the same cycle
    strobe = 1'b1; step("R5", 4'h1, 0, 0, 0);
    wrCount = 1'b1; wrData = 4'hF; step("R9", 4'hF, 0, 0, 0);
    strobe = 1'b1; step("R5", 4'h0, 1, 1, 1);
    wrCount = 1'b1; wrData = 4'hF; step("R9", 4'hF, 1, 0, 1);
    flagClr = 1'b1; strobe = 1'b1; step("R6", 4'h0, 1, 1, 1);
    flagClr = 1'b1; step("R6", 4'h0, 0, 0, 0);

    // R9 load beats an increment from 0xF: no flag, no carry
    wrCount = 1'b1; wrData = 4'hF; strobe = 1'b1; step("R9", 4'hF, 0, 0, 0);
    step("R9", 4'hF, 0, 0, 0);

    // R11 preloaded 0xF, single pin edge raises the interrupt
    extPin = 1'b1;
    step("R11", 4'hF, 0, 0, 0);
    step("R11", 4'hF, 0, 0, 0);
    step("R11", 4'h0, 1, 1, 1);
    step("R11", 4'h0, 1, 0, 1);

    // R10 strobe plus pin edge in one cycle
    flagClr = 1'b1; step("R6", 4'h0, 0, 0, 0);
    wrCount = 1'b1; wrData = 4'h5; step("R9", 4'h5, 0, 0, 0);
    extPin = 1'b0;
    step("R10", 4'h5, 0, 0, 0);
    step("R10", 4'h5, 0, 0, 0);
    strobe = 1'b1; step("R10", 4'h7, 0, 0, 0);
    wrCount = 1'b1; wrData = 4'hF; step("R9", 4'hF, 0, 0, 0);
    extPin = 1'b1;
    step("R10", 4'hF, 0, 0, 0);
    step("R10", 4'hF, 0, 0, 0);
    strobe = 1'b1; step("R10", 4'h1, 1, 1, 1);
    ovfIntEn = 1'b0; step("R7", 4'h1, 1, 0, 0);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule